// File: doc/BRIEF.md
# Double-Banked Endpoint Buffer Control Register

This block is the control and status register for one endpoint buffer made of two banks. One bank is filled or drained by the serial interface engine (SIE). The other is owned by the CPU. The CPU reaches the block through a 16-bit register at a fixed offset on a simple register bus. A 3-bit selector names the current pipe, and pipe 0 is the default control pipe.

For an OUT pipe running in continuous transfer mode, software can hand a partly filled SIE bank over to the CPU before that bank is full. The handover raises the buffer-ready interrupt. For an IN pipe, software can empty the SIE bank and pass the emptied bank to the CPU. A clear that would land while the SIE is still using the buffer is refused, and the refusal is recorded in a sticky error flag. The register also reports whether the SIE is using the buffer of the selected pipe. The block keeps a byte count for each bank, so the results of a handover or a clear can be seen at its ports.

Both commands are rejected for the default control pipe. Both are rejected for the wrong pipe direction. The block holds no packet logic and no buffer storage.

Top module: `pipe_buf_ctrl`

## Requirements
- R1: The asynchronous reset `rst_ni` returns `swap_o`, `clr_o`, `brdy_o`, `err_o` and both byte counts to 0. So does the synchronous `sw_rst_i` at the next clock edge. With the SIE idle, the register then reads 0x0000.
- R2: A write to offset 0x2E with bit 15 = 1 starts a handover when four conditions hold. The selected pipe is an OUT pipe (its `pipe_dir_i` bit is 0). `cont_mode_i` is 1. The SIE bank is not full. The pipe select is not 0. In the cycle after the write edge, `swap_o` and `brdy_o` are both 1 for exactly one cycle. In that same cycle `cpu_cnt_o` equals the SIE count from before the write, and `sie_cnt_o` is 0.
- R3: A handover does not happen, and neither strobe nor count changes, in any of these cases: bit 15 is written as 0, the pipe is an IN pipe, `cont_mode_i` is 0, the SIE bank is full, or the pipe select is 0.
- R4: A write to offset 0x2E with bit 14 = 1 starts a clear when three conditions hold. The selected pipe is an IN pipe (its `pipe_dir_i` bit is 1). The pipe select is not 0. The SIE is not using that pipe's buffer. In the cycle after the write edge, `clr_o` is 1 for one cycle, and both byte counts are 0.
- R5: A clear does not happen, and no count changes, in any of these cases: bit 14 is written as 0, the pipe is an OUT pipe, or the pipe select is 0.
- R6: A write of bit 14 = 1 on an IN pipe other than pipe 0, while the SIE is using that pipe's buffer, is refused. `clr_o` stays 0 and the counts are unchanged. `err_o` becomes 1 in the following cycle. It stays 1 until `rst_ni` or `sw_rst_i` clears it.
- R7: Reading offset 0x2E returns bit 13 = `sie_busy_i` of the selected pipe. That bit reads 0 when the pipe select is 0. Bits 15, 14 and 12..0 always read 0. Any other offset reads 0x0000, and writes to any other offset have no effect.
- R8: Each cycle with `sie_byte_i` = 1 adds one to `sie_cnt_o`. The count stops at `BUF_BYTES`, which is the full condition. A handover or a clear in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| sw_rst_i | input | 1 | Synchronous software reset |
| we_i | input | 1 | Register write enable |
| addr_i | input | ADDR_W | Register offset |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data (combinational on `addr_i`) |
| cur_pipe_i | input | PIPE_W | Current pipe select, 0 = default control pipe |
| pipe_dir_i | input | NUM_PIPES | Direction per pipe, 1 = IN, 0 = OUT |
| cont_mode_i | input | 1 | Continuous transfer mode of the current pipe |
| sie_busy_i | input | NUM_PIPES | SIE access in progress, per pipe |
| sie_byte_i | input | 1 | SIE stores one byte into its bank |
| swap_o | output | 1 | One-cycle bank handover strobe |
| clr_o | output | 1 | One-cycle SIE bank clear strobe |
| brdy_o | output | 1 | One-cycle buffer-ready interrupt pulse |
| err_o | output | 1 | Sticky flag: a clear was refused |
| sie_cnt_o | output | CNT_W | Byte count of the SIE-side bank |
| cpu_cnt_o | output | CNT_W | Byte count of the CPU-side bank |

## Verification
The assertions take the pipe select, direction, mode and busy inputs to be stable in the cycle of a register write. They also take `sw_rst_i` to be a clean synchronous level. The bench meets both conditions by changing every input only on the falling clock edge, and by holding the pipe configuration constant across each write.

The bench never pulses `sie_byte_i` in the same cycle as a command write, so the counts after a write follow from the fill and the command alone. The sweep covers every pipe, both directions, both modes, busy and idle, and partial and full banks. Each of these is combined with four write patterns. The per-pipe direction and busy vectors are driven with the opposite value on every pipe that is not selected. A wrong pipe selection would therefore show up as an error.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
  localparam int REG_W    = 16;
  localparam int TGL_BIT  = 15;
  localparam int CLR_BIT  = 14;
  localparam int BUSY_BIT = 13;

  typedef struct packed {
    logic dcp;
    logic is_in;
    logic busy;
  } pipe_info_t;

  typedef struct packed {
    logic swap;
    logic clr;
    logic refuse;
  } cmd_t;
endpackage

// File: rtl/pbc_pipe_sel.sv
module pbc_pipe_sel
  import pbc_pkg::*;
#(
  parameter int NUM_PIPES = 8,
  parameter int PIPE_W    = 3
) (
  input  logic [PIPE_W-1:0]    cur_pipe_i,
  input  logic [NUM_PIPES-1:0] pipe_dir_i,
  input  logic [NUM_PIPES-1:0] sie_busy_i,
  output pipe_info_t           info_o
);
  logic [NUM_PIPES-1:0] hit;

  for (genvar g = 0; g < NUM_PIPES; g++) begin : g_hit
    assign hit[g] = (cur_pipe_i == PIPE_W'(g));
  end

  always_comb begin
    info_o.dcp   = (cur_pipe_i == '0);
    info_o.is_in = |(hit & pipe_dir_i);
    info_o.busy  = |(hit & sie_busy_i);
  end
endmodule

// File: rtl/pbc_cmd_dec.sv
module pbc_cmd_dec
  import pbc_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] REG_OFF = 8'h2E
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  pipe_info_t        info_i,
  input  logic              cont_mode_i,
  input  logic              full_i,
  output cmd_t              cmd_o,
  output logic [REG_W-1:0]  rdata_o
);
  logic hit, wr, clr_req;

  assign hit     = (addr_i == REG_OFF);
  assign wr      = we_i && hit;
  assign clr_req = wr && wdata_i[CLR_BIT] && info_i.is_in && !info_i.dcp;

  always_comb begin
    cmd_o.swap   = wr && wdata_i[TGL_BIT] && !info_i.is_in && cont_mode_i
                   && !full_i && !info_i.dcp;
    cmd_o.clr    = clr_req && !info_i.busy;
    cmd_o.refuse = clr_req && info_i.busy;
  end

  // command bits are strobes; only the busy flag is visible
  always_comb begin
    rdata_o = '0;
    if (hit) rdata_o[BUSY_BIT] = info_i.busy && !info_i.dcp;
  end

  always_comb begin
    a_r7_reserved_zero: assert (rdata_o[12:0] == '0 && rdata_o[15:14] == '0);
  end
endmodule

// File: rtl/pbc_bank_cnt.sv
module pbc_bank_cnt #(
  parameter int BUF_BYTES = 64,
  parameter int CNT_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_rst_i,
  input  logic             byte_i,
  input  logic             swap_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] sie_cnt_o,
  output logic [CNT_W-1:0] cpu_cnt_o,
  output logic             full_o
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(BUF_BYTES);

  assign full_o = (sie_cnt_o == CAP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sie_cnt_o <= '0;
      cpu_cnt_o <= '0;
    end else if (sw_rst_i) begin
      sie_cnt_o <= '0;
      cpu_cnt_o <= '0;
    end else if (swap_i) begin
      cpu_cnt_o <= sie_cnt_o;
      sie_cnt_o <= '0;
    end else if (clr_i) begin
      cpu_cnt_o <= '0;
      sie_cnt_o <= '0;
    end else if (byte_i && !full_o) begin
      sie_cnt_o <= sie_cnt_o + 1'b1;
    end
  end

  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sie_cnt_o <= CAP);

  a_r2_count_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_i && !sw_rst_i |=> cpu_cnt_o == $past(sie_cnt_o) && sie_cnt_o == '0);

  a_r8_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !swap_i && !clr_i && !sw_rst_i |=> sie_cnt_o - $past(sie_cnt_o) <= CNT_W'(1));
endmodule

// File: rtl/pipe_buf_ctrl.sv
module pipe_buf_ctrl
  import pbc_pkg::*;
#(
  parameter int          NUM_PIPES = 8,
  parameter int          PIPE_W    = $clog2(NUM_PIPES),
  parameter int          ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] REG_OFF = 8'h2E,
  parameter int          BUF_BYTES = 64,
  parameter int          CNT_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sw_rst_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [15:0]          wdata_i,
  output logic [15:0]          rdata_o,
  input  logic [PIPE_W-1:0]    cur_pipe_i,
  input  logic [NUM_PIPES-1:0] pipe_dir_i,
  input  logic                 cont_mode_i,
  input  logic [NUM_PIPES-1:0] sie_busy_i,
  input  logic                 sie_byte_i,
  output logic                 swap_o,
  output logic                 clr_o,
  output logic                 brdy_o,
  output logic                 err_o,
  output logic [CNT_W-1:0]     sie_cnt_o,
  output logic [CNT_W-1:0]     cpu_cnt_o
);
  pipe_info_t info;
  cmd_t       cmd;
  logic       full;
  logic       swap_q, clr_q, brdy_q, err_q;

  pbc_pipe_sel #(.NUM_PIPES(NUM_PIPES), .PIPE_W(PIPE_W)) u_sel (
    .cur_pipe_i (cur_pipe_i),
    .pipe_dir_i (pipe_dir_i),
    .sie_busy_i (sie_busy_i),
    .info_o     (info)
  );

  pbc_cmd_dec #(.ADDR_W(ADDR_W), .REG_OFF(REG_OFF)) u_dec (
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .info_i      (info),
    .cont_mode_i (cont_mode_i),
    .full_i      (full),
    .cmd_o       (cmd),
    .rdata_o     (rdata_o)
  );

  pbc_bank_cnt #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sw_rst_i  (sw_rst_i),
    .byte_i    (sie_byte_i),
    .swap_i    (cmd.swap),
    .clr_i     (cmd.clr),
    .sie_cnt_o (sie_cnt_o),
    .cpu_cnt_o (cpu_cnt_o),
    .full_o    (full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      swap_q <= 1'b0;
      clr_q  <= 1'b0;
      brdy_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (sw_rst_i) begin
      swap_q <= 1'b0;
      clr_q  <= 1'b0;
      brdy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      swap_q <= cmd.swap;
      clr_q  <= cmd.clr;
      brdy_q <= cmd.swap;
      err_q  <= err_q | cmd.refuse;
    end
  end

  assign swap_o = swap_q;
  assign clr_o  = clr_q;
  assign brdy_o = brdy_q;
  assign err_o  = err_q;

  a_r2_no_dcp_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_o |-> $past(cur_pipe_i) != '0);

  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_o |=> !swap_o || $past(we_i));

  a_r4_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |-> sie_cnt_o == '0 && cpu_cnt_o == '0);

  a_r5_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(swap_o && clr_o));

  a_r6_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !sw_rst_i |=> err_o);

  a_r1_sw_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |=> !err_o && !swap_o && !clr_o && sie_cnt_o == '0);
endmodule

// File: tb/sim_pipe_buf_ctrl.sv
`timescale 1ns/1ps
module sim_pipe_buf_ctrl;
  localparam int NP = 8, PW = 3, AW = 8, BB = 64, CW = 7;

  logic clk = 1'b0, rst_ni = 1'b0, sw_rst = 1'b0, we = 1'b0, sie_byte = 1'b0, cont = 1'b0;
  logic [AW-1:0] addr = 8'h2E;
  logic [15:0] wdata = '0, rdata;
  logic [PW-1:0] pipe = '0;
  logic [NP-1:0] dir_v = '0, busy_v = '0;
  logic swap, clr, brdy, err;
  logic [CW-1:0] sie_cnt, cpu_cnt;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pipe_buf_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sw_rst_i(sw_rst), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cur_pipe_i(pipe), .pipe_dir_i(dir_v),
    .cont_mode_i(cont), .sie_busy_i(busy_v), .sie_byte_i(sie_byte),
    .swap_o(swap), .clr_o(clr), .brdy_o(brdy), .err_o(err),
    .sie_cnt_o(sie_cnt), .cpu_cnt_o(cpu_cnt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_sw_rst();
    @(negedge clk) sw_rst = 1'b1;
    @(negedge clk) sw_rst = 1'b0;
  endtask

  task automatic fill(input int n);
    if (n > 0) begin
      @(negedge clk) sie_byte = 1'b1;
      repeat (n) @(negedge clk);
      sie_byte = 1'b0;
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; wdata = '0; addr = 8'h2E;
  endtask

  initial begin
    automatic logic [15:0] pats[4] = '{16'h8000, 16'h4000, 16'hC000, 16'h3FFF};
    repeat (3) @(negedge clk);
    chk("R1 hw reset swap", swap, 0);
    chk("R1 hw reset err", err, 0);
    chk("R1 hw reset cnt", {sie_cnt, cpu_cnt}, 0);
    chk("R1 hw reset rdata", rdata, 16'h0000);
    rst_ni = 1'b1;

    for (int p = 0; p < NP; p++)
      for (int d = 0; d < 2; d++)
        for (int c = 0; c < 2; c++)
          for (int b = 0; b < 2; b++)
            for (int f = 0; f < 2; f++)
              for (int w = 0; w < 4; w++) begin
                automatic int n = f ? BB : (p * 3 + w + 1);
                automatic logic [15:0] v = pats[w];
                automatic bit dcp = (p == 0);
                automatic bit ex_swap = v[15] && d == 0 && c == 1 && f == 0 && !dcp;
                automatic bit ex_clr = v[14] && d == 1 && !dcp && b == 0;
                automatic bit ex_err = v[14] && d == 1 && !dcp && b == 1;
                do_sw_rst();
                chk("R1 sw reset cnt", {sie_cnt, cpu_cnt, err}, 0);
                pipe = PW'(p); cont = c[0];
                dir_v = d ? (NP'(1) << p) : ~(NP'(1) << p);
                busy_v = b ? (NP'(1) << p) : ~(NP'(1) << p);
                fill(f ? n + 2 : n);
                chk("R8 fill count", sie_cnt, n);
                @(negedge clk);
                chk("R7 read busy", rdata, (b && !dcp) ? 16'h2000 : 16'h0000);
                wr(8'h2E, v);
                chk("R2 swap_o", swap, ex_swap);
                chk("R2 brdy_o", brdy, ex_swap);
                chk(ex_clr ? "R4 clr_o" : "R5 clr_o", clr, ex_clr);
                chk("R6 err_o", err, ex_err);
                chk(ex_swap ? "R2 sie_cnt" : (ex_clr ? "R4 sie_cnt" : "R3 sie_cnt"),
                    sie_cnt, (ex_swap || ex_clr) ? 0 : n);
                chk(ex_swap ? "R2 cpu_cnt" : "R5 cpu_cnt", cpu_cnt, ex_swap ? n : 0);
                @(negedge clk);
                chk("R2 strobes one cycle", {swap, clr, brdy}, 0);
                chk("R7 cmd bits read 0", rdata & 16'hDFFF, 0);
                if (ex_err) begin
                  wr(8'h2E, 16'h0000);
                  chk("R6 err sticky", err, 1);
                end
              end

    // other offset: write ignored, reads zero
    do_sw_rst();
    pipe = 3'd3; cont = 1'b1; dir_v = '0; busy_v = 8'h08;
    fill(4);
    addr = 8'h2C;
    @(negedge clk);
    chk("R7 other offset read", rdata, 0);
    wr(8'h2C, 16'hC000);
    chk("R7 other offset no swap", swap, 0);
    chk("R7 other offset counts", {sie_cnt, cpu_cnt}, {7'd4, 7'd0});
    // hw reset clears err mid-run
    dir_v = 8'hFF;
    wr(8'h2E, 16'h4000);
    chk("R6 refused sets err", err, 1);
    @(negedge clk) rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 hw reset clears err", {err, sie_cnt}, 0);
    rst_ni = 1'b1;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule